// File: doc/BRIEF.md
# USB Charger Type Detection Sequencer

This block runs the charging-port detection sequence on a USB 2.0 PHY and classifies the port that is attached. It works in three steps: contact detection, primary detection and secondary detection. Each step turns on a pair of analog enables for the PHY and reads a comparator once its timed window ends. The result is one of four port classes. A floating port is reported when contact detection runs out of polls and primary detection then fails.

A single-cycle `start_i` pulse launches a run. The PHY is held suspended and in non-driving mode while the analog enables are active. All timing comes from the rising edges of a one-cycle `ms_tick_i` strobe, and the window lengths are parameters. At the end of a run, `done_o` pulses once and `chg_type_o` carries the classification.

Top module: `usb_chg_detect`

## Requirements
- R1: After reset all enables, `busy_o`, `done_o`, suspend and non-driving are low, and `chg_type_o` reads 0.
- R2: A `start_i` pulse while idle raises `busy_o` and asserts suspend and non-driving on the next cycle. `busy_o` then stays high up to and including the `done_o` cycle and drops on the cycle after it.
- R3: Contact detection turns on the DM pull-down and the DP current source together. It samples `contact_i` each time POLL_MS ticks have elapsed, and makes at most DCD_POLLS samples.
- R4: When contact is sampled high, or the last poll has been taken, primary detection starts. The DP voltage source and the DM current sink come on in the same cycle that the contact enables go off.
- R5: Each primary attempt lasts PRI_MS ticks and then samples `cp_det_i`. A high sample moves the run to secondary detection, including after a contact timeout.
- R6: If a primary sample is low and all DCD_POLLS polls were used, the result is 4 (floating). This holds even when contact was first seen on the last poll.
- R7: If a primary sample is low after contact was seen early, up to PRI_RETRIES further attempts follow. Each one is preceded by one cycle with the primary enables off. If every attempt fails, the result is 1 (standard downstream).
- R8: Secondary detection turns on the DM voltage source and the DP current sink for SEC_MS ticks, then samples `dcp_det_i`. A high sample gives 2 (dedicated charging) and a low sample gives 3 (charging downstream).
- R9: A run ends with one cycle in which normal mode is restored while suspend stays high. It is followed by one `done_o` cycle with suspend released. `chg_type_o` is 0 from start until the result is known, and then holds the result until the next start.
- R10: A `start_i` pulse while `busy_o` is high has no effect on the run, its outputs or its single `done_o` pulse.
- R11: The enables of at most one detection step are on at a time. Any analog enable is on only while suspend and non-driving are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| ms_tick_i | input | 1 | One-cycle millisecond strobe |
| contact_i | input | 1 | Data contact comparator |
| cp_det_i | input | 1 | Charging-port comparator |
| dcp_det_i | input | 1 | Dedicated-port comparator |
| phy_suspend_o | output | 1 | PHY suspend request |
| opmode_nondrv_o | output | 1 | Non-driving operating mode |
| dm_pulldown_en_o | output | 1 | DM pull-down enable |
| dp_isrc_en_o | output | 1 | DP current source enable |
| dp_vsrc_en_o | output | 1 | DP voltage source enable |
| dm_isink_en_o | output | 1 | DM current sink enable |
| dm_vsrc_en_o | output | 1 | DM voltage source enable |
| dp_isink_en_o | output | 1 | DP current sink enable |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| chg_type_o | output | 3 | 0 unknown, 1 standard downstream, 2 dedicated, 3 charging downstream, 4 floating |

## Verification
The assertions check the rules that hold in every cycle. These are the exclusivity of the detection steps, analog enables only while suspended and non-driving, the hand-over from contact to primary enables, the ordering of secondary after primary, the restore-then-release order at the end, and the start/busy/done relationship. Only the bench's scenarios can show the classification itself. That covers the poll and retry counts, the timeout that turns a late contact into floating, a charging-port comparator that rises during the last retry, and a second start ignored during a run. The bench compares these against a behavioural model on every cycle.

// File: rtl/chg_det_pkg.sv
package chg_det_pkg;
  typedef enum logic [2:0] {
    CHG_NONE  = 3'd0,
    CHG_SDP   = 3'd1,
    CHG_DCP   = 3'd2,
    CHG_CDP   = 3'd3,
    CHG_FLOAT = 3'd4
  } chg_type_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_CONTACT,
    ST_PRIMARY,
    ST_PRI_GAP,
    ST_SECONDARY,
    ST_RESTORE,
    ST_FINISH
  } seq_state_e;

  typedef struct packed {
    logic suspend;
    logic nondrv;
    logic dm_pd;
    logic dp_isrc;
    logic dp_vsrc;
    logic dm_isink;
    logic dm_vsrc;
    logic dp_isink;
    logic busy;
    logic done;
  } drive_t;
endpackage

// File: rtl/chg_ms_timer.sv
module chg_ms_timer #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || expire_o)  cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_det_pkg::*;
#(
  parameter int unsigned POLL_MS     = 100,
  parameter int unsigned PRI_MS      = 40,
  parameter int unsigned SEC_MS      = 40,
  parameter int unsigned DCD_POLLS   = 6,
  parameter int unsigned PRI_RETRIES = 2,
  parameter int unsigned CNT_W       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             contact_i,
  input  logic             cp_det_i,
  input  logic             dcp_det_i,
  input  logic             expire_i,
  output seq_state_e       state_o,
  output logic             timer_clr_o,
  output logic [CNT_W-1:0] limit_o,
  output chg_type_e        chg_type_o
);
  localparam int unsigned POLL_W = $clog2(DCD_POLLS + 1);
  localparam int unsigned TRY_W  = $clog2(PRI_RETRIES + 2);
  localparam logic [CNT_W-1:0]  POLL_LIM  = CNT_W'(POLL_MS);
  localparam logic [CNT_W-1:0]  PRI_LIM   = CNT_W'(PRI_MS);
  localparam logic [CNT_W-1:0]  SEC_LIM   = CNT_W'(SEC_MS);
  localparam logic [POLL_W-1:0] LAST_POLL = POLL_W'(DCD_POLLS - 1);
  localparam logic [TRY_W-1:0]  TRY_LIM   = TRY_W'(PRI_RETRIES);

  seq_state_e        state_q, state_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic [TRY_W-1:0]  try_q, try_d;
  logic              tmo_q, tmo_d;
  chg_type_e         type_q, type_d;

  always_comb begin
    state_d = state_q;
    poll_d  = poll_q;
    try_d   = try_q;
    tmo_d   = tmo_q;
    type_d  = type_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_ENTER;
        type_d  = CHG_NONE;
      end
      ST_ENTER: begin
        state_d = ST_CONTACT;
        poll_d  = '0;
        tmo_d   = 1'b0;
      end
      ST_CONTACT: if (expire_i) begin
        if (contact_i || poll_q == LAST_POLL) begin
          state_d = ST_PRIMARY;
          tmo_d   = (poll_q == LAST_POLL);  // late contact still counts as timeout
          try_d   = '0;
        end else begin
          poll_d = poll_q + POLL_W'(1);
        end
      end
      ST_PRIMARY: if (expire_i) begin
        if (cp_det_i) begin
          state_d = ST_SECONDARY;
        end else if (tmo_q) begin
          state_d = ST_RESTORE;
          type_d  = CHG_FLOAT;
        end else if (try_q == TRY_LIM) begin
          state_d = ST_RESTORE;
          type_d  = CHG_SDP;
        end else begin
          state_d = ST_PRI_GAP;
          try_d   = try_q + TRY_W'(1);
        end
      end
      ST_PRI_GAP: state_d = ST_PRIMARY;
      ST_SECONDARY: if (expire_i) begin
        state_d = ST_RESTORE;
        type_d  = dcp_det_i ? CHG_DCP : CHG_CDP;
      end
      ST_RESTORE: state_d = ST_FINISH;
      ST_FINISH:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_PRIMARY:   limit_o = PRI_LIM;
      ST_SECONDARY: limit_o = SEC_LIM;
      default:      limit_o = POLL_LIM;
    endcase
  end

  assign timer_clr_o = (state_d != state_q);
  assign state_o     = state_q;
  assign chg_type_o  = type_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      poll_q  <= '0;
      try_q   <= '0;
      tmo_q   <= 1'b0;
      type_q  <= CHG_NONE;
    end else begin
      state_q <= state_d;
      poll_q  <= poll_d;
      try_q   <= try_d;
      tmo_q   <= tmo_d;
      type_q  <= type_d;
    end
  end
endmodule

// File: rtl/chg_drive_decode.sv
module chg_drive_decode
  import chg_det_pkg::*;
(
  input  seq_state_e state_i,
  output drive_t     drv_o
);
  always_comb begin
    drv_o = '0;
    unique case (state_i)
      ST_IDLE: ;
      ST_ENTER: begin
        drv_o.suspend = 1'b1; drv_o.nondrv = 1'b1; drv_o.busy = 1'b1;
      end
      ST_CONTACT: begin
        drv_o.suspend = 1'b1; drv_o.nondrv = 1'b1; drv_o.busy = 1'b1;
        drv_o.dm_pd = 1'b1;   drv_o.dp_isrc = 1'b1;
      end
      ST_PRIMARY: begin
        drv_o.suspend = 1'b1; drv_o.nondrv = 1'b1; drv_o.busy = 1'b1;
        drv_o.dp_vsrc = 1'b1; drv_o.dm_isink = 1'b1;
      end
      ST_PRI_GAP: begin
        drv_o.suspend = 1'b1; drv_o.nondrv = 1'b1; drv_o.busy = 1'b1;
      end
      ST_SECONDARY: begin
        drv_o.suspend = 1'b1; drv_o.nondrv = 1'b1; drv_o.busy = 1'b1;
        drv_o.dm_vsrc = 1'b1; drv_o.dp_isink = 1'b1;
      end
      ST_RESTORE: begin
        drv_o.suspend = 1'b1; drv_o.busy = 1'b1;
      end
      ST_FINISH: begin
        drv_o.busy = 1'b1; drv_o.done = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/usb_chg_detect.sv
module usb_chg_detect
  import chg_det_pkg::*;
#(
  parameter int unsigned POLL_MS     = 100,
  parameter int unsigned PRI_MS      = 40,
  parameter int unsigned SEC_MS      = 40,
  parameter int unsigned DCD_POLLS   = 6,
  parameter int unsigned PRI_RETRIES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       ms_tick_i,
  input  logic       contact_i,
  input  logic       cp_det_i,
  input  logic       dcp_det_i,
  output logic       phy_suspend_o,
  output logic       opmode_nondrv_o,
  output logic       dm_pulldown_en_o,
  output logic       dp_isrc_en_o,
  output logic       dp_vsrc_en_o,
  output logic       dm_isink_en_o,
  output logic       dm_vsrc_en_o,
  output logic       dp_isink_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] chg_type_o
);
  localparam int unsigned MS_MAX = (POLL_MS > PRI_MS)
                                 ? ((POLL_MS > SEC_MS) ? POLL_MS : SEC_MS)
                                 : ((PRI_MS > SEC_MS) ? PRI_MS : SEC_MS);
  localparam int unsigned CNT_W  = $clog2(MS_MAX + 1);

  seq_state_e       state;
  logic             timer_clr, expire;
  logic [CNT_W-1:0] limit;
  chg_type_e        chg_type;
  drive_t           drv;

  chg_ms_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (timer_clr),
    .tick_i   (ms_tick_i),
    .limit_i  (limit),
    .expire_o (expire)
  );

  chg_seq_fsm #(
    .POLL_MS    (POLL_MS),
    .PRI_MS     (PRI_MS),
    .SEC_MS     (SEC_MS),
    .DCD_POLLS  (DCD_POLLS),
    .PRI_RETRIES(PRI_RETRIES),
    .CNT_W      (CNT_W)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .contact_i   (contact_i),
    .cp_det_i    (cp_det_i),
    .dcp_det_i   (dcp_det_i),
    .expire_i    (expire),
    .state_o     (state),
    .timer_clr_o (timer_clr),
    .limit_o     (limit),
    .chg_type_o  (chg_type)
  );

  chg_drive_decode i_decode (
    .state_i (state),
    .drv_o   (drv)
  );

  assign phy_suspend_o    = drv.suspend;
  assign opmode_nondrv_o  = drv.nondrv;
  assign dm_pulldown_en_o = drv.dm_pd;
  assign dp_isrc_en_o     = drv.dp_isrc;
  assign dp_vsrc_en_o     = drv.dp_vsrc;
  assign dm_isink_en_o    = drv.dm_isink;
  assign dm_vsrc_en_o     = drv.dm_vsrc;
  assign dp_isink_en_o    = drv.dp_isink;
  assign busy_o           = drv.busy;
  assign done_o           = drv.done;
  assign chg_type_o       = chg_type;
endmodule

// File: rtl/chg_det_checker.sv
module chg_det_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       phy_suspend_o,
  input logic       opmode_nondrv_o,
  input logic       dm_pulldown_en_o,
  input logic       dp_isrc_en_o,
  input logic       dp_vsrc_en_o,
  input logic       dm_isink_en_o,
  input logic       dm_vsrc_en_o,
  input logic       dp_isink_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] chg_type_o
);
  logic any_analog;
  assign any_analog = dm_pulldown_en_o | dp_isrc_en_o | dp_vsrc_en_o |
                      dm_isink_en_o | dm_vsrc_en_o | dp_isink_en_o;

  a_r11_one_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dm_pulldown_en_o | dp_isrc_en_o,
              dp_vsrc_en_o | dm_isink_en_o,
              dm_vsrc_en_o | dp_isink_en_o}));

  a_r11_analog_in_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_analog |-> (phy_suspend_o && opmode_nondrv_o));

  a_r2_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r2_busy_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  a_r9_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r9_restore_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!phy_suspend_o && $past(phy_suspend_o) && !$past(opmode_nondrv_o)));

  a_r9_result_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (chg_type_o >= 3'd1 && chg_type_o <= 3'd4));

  a_r4_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dm_pulldown_en_o) |-> (dp_vsrc_en_o && dm_isink_en_o));

  a_r8_after_primary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dm_vsrc_en_o) |-> $past(dp_vsrc_en_o));
endmodule

bind usb_chg_detect chg_det_checker i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .start_i          (start_i),
  .phy_suspend_o    (phy_suspend_o),
  .opmode_nondrv_o  (opmode_nondrv_o),
  .dm_pulldown_en_o (dm_pulldown_en_o),
  .dp_isrc_en_o     (dp_isrc_en_o),
  .dp_vsrc_en_o     (dp_vsrc_en_o),
  .dm_isink_en_o    (dm_isink_en_o),
  .dm_vsrc_en_o     (dm_vsrc_en_o),
  .dp_isink_en_o    (dp_isink_en_o),
  .busy_o           (busy_o),
  .done_o           (done_o),
  .chg_type_o       (chg_type_o)
);

// File: tb/test_usb_chg_detect.sv
module test_usb_chg_detect;
  localparam int POLL = 3, PRI = 2, SEC = 2, POLLS = 6, RETR = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, tick = 1'b0, contact = 1'b0, cp = 1'b0, dcp = 1'b0;
  logic sus, ndrv, dm_pd, dp_isrc, dp_vsrc, dm_isink, dm_vsrc, dp_isink, busy, done;
  logic [2:0] ctype;

  always #5 clk = ~clk;

  usb_chg_detect #(.POLL_MS(POLL), .PRI_MS(PRI), .SEC_MS(SEC),
                   .DCD_POLLS(POLLS), .PRI_RETRIES(RETR)) i_usb_chg_detect (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ms_tick_i(tick),
    .contact_i(contact), .cp_det_i(cp), .dcp_det_i(dcp),
    .phy_suspend_o(sus), .opmode_nondrv_o(ndrv),
    .dm_pulldown_en_o(dm_pd), .dp_isrc_en_o(dp_isrc),
    .dp_vsrc_en_o(dp_vsrc), .dm_isink_en_o(dm_isink),
    .dm_vsrc_en_o(dm_vsrc), .dp_isink_en_o(dp_isink),
    .busy_o(busy), .done_o(done), .chg_type_o(ctype));

  int n_chk = 0, n_fail = 0, done_cnt = 0;
  int last_type = 0;
  bit finished = 0;

  // behavioural reference: phase 0 idle,1 enter,2 contact,3 primary,4 gap,5 secondary,6 restore,7 done
  int m_ph = 0, m_ms = 0, m_polls = 0, m_tries = 0, m_type = 0;
  bit m_tmo = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ms = 0; m_polls = 0; m_tries = 0; m_type = 0; m_tmo = 0;
    end else begin
      case (m_ph)
        0: if (start) begin m_ph = 1; m_type = 0; end
        1: begin m_ph = 2; m_ms = 0; m_polls = 0; end
        2: if (tick) begin
          m_ms++;
          if (m_ms == POLL) begin
            m_ms = 0; m_polls++;
            if (contact || m_polls == POLLS) begin
              m_tmo = (m_polls == POLLS); m_tries = 0; m_ph = 3;
            end
          end
        end
        3: if (tick) begin
          m_ms++;
          if (m_ms == PRI) begin
            m_ms = 0;
            if (cp) m_ph = 5;
            else if (m_tmo) begin m_type = 4; m_ph = 6; end
            else if (m_tries == RETR) begin m_type = 1; m_ph = 6; end
            else begin m_tries++; m_ph = 4; end
          end
        end
        4: begin m_ph = 3; m_ms = 0; end
        5: if (tick) begin
          m_ms++;
          if (m_ms == SEC) begin m_ms = 0; m_type = dcp ? 2 : 3; m_ph = 6; end
        end
        6: m_ph = 7;
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2", "busy", busy, m_ph != 0);
    chk("R9", "suspend", sus, m_ph >= 1 && m_ph <= 6);
    chk("R9", "nondrv", ndrv, m_ph >= 1 && m_ph <= 5);
    chk("R3", "dm_pulldown", dm_pd, m_ph == 2);
    chk("R3", "dp_isrc", dp_isrc, m_ph == 2);
    chk("R4", "dp_vsrc", dp_vsrc, m_ph == 3);
    chk("R5", "dm_isink", dm_isink, m_ph == 3);
    chk("R8", "dm_vsrc", dm_vsrc, m_ph == 5);
    chk("R8", "dp_isink", dp_isink, m_ph == 5);
    chk("R9", "done", done, m_ph == 7);
    chk("R9", "type", ctype, m_type);
    chk("R11", "stage_overlap",
        ((dm_pd | dp_isrc) + (dp_vsrc | dm_isink) + (dm_vsrc | dp_isink)) <= 1, 1);
    if (done) begin done_cnt++; last_type = ctype; end
  end

  task automatic tick_one();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic ticks_until_done(int d0);
    for (int g = 0; g < 400 && done_cnt == d0; g++) tick_one();
  endtask

  task automatic finish_case(string tag, int d0, int exp);
    ticks_until_done(d0);
    repeat (4) @(negedge clk);
    chk(tag, "done_pulses", done_cnt - d0, 1);
    chk(tag, "result", last_type, exp);
    chk("R9", "held_result", ctype, exp);
  endtask

  task automatic run_case(string tag, logic c, logic p, logic d, int exp);
    int d0;
    contact = c; cp = p; dcp = d;
    d0 = done_cnt;
    pulse_start();
    finish_case(tag, d0, exp);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset_busy", busy, 0);
    chk("R1", "reset_enables", {sus, ndrv, dm_pd, dp_isrc, dp_vsrc, dm_isink, dm_vsrc, dp_isink, done}, 0);
    chk("R1", "reset_type", ctype, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case("R7", 1, 0, 0, 1);   // all primary attempts fail
    run_case("R8", 1, 1, 1, 2);   // dedicated
    run_case("R8", 1, 1, 0, 3);   // charging downstream
    run_case("R6", 0, 0, 0, 4);   // no contact, floating
    run_case("R5", 0, 1, 1, 2);   // timeout yet primary passes

    // R6: contact first seen on the final poll
    contact = 0; cp = 0; dcp = 0;
    d0 = done_cnt;
    pulse_start();
    repeat ((POLLS - 1) * POLL) tick_one();
    contact = 1;
    finish_case("R6", d0, 4);

    // R7: comparator rises in the last retry
    contact = 1; cp = 0; dcp = 0;
    d0 = done_cnt;
    pulse_start();
    repeat (POLL + 2 * PRI) tick_one();
    cp = 1;
    finish_case("R7", d0, 3);

    // R10: second start during a run is ignored
    contact = 1; cp = 1; dcp = 1;
    d0 = done_cnt;
    pulse_start();
    repeat (2) tick_one();
    pulse_start();
    chk("R10", "busy_after_restart", busy, 1);
    finish_case("R10", d0, 2);
    repeat (20) @(negedge clk);
    chk("R10", "no_extra_done", done_cnt - d0, 1);

    finished = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule